// File: doc/BRIEF.md
# Split Seconds/Nanoseconds Time-of-Day Counter

This block keeps wall-clock time as a 64-bit count of whole seconds plus a nanoseconds field that always stays below one billion. It runs freely from reset. On every clock cycle the nanoseconds field grows by the clock period, a fixed whole number of nanoseconds set by a parameter. When the field would reach one billion, it keeps only the excess and the seconds count goes up by one. The carry ripples from the low seconds word into the high one.

Software reaches the counter through a simple register bus that it shares with a neighbouring timer. It can read the seconds in two 32-bit halves, the nanoseconds, and the configured period. It can also write any of the three time fields to set the clock, and counting goes on from the written value. The three fields are not captured together on a read. Software gets a consistent value by reading the low seconds word, then the nanoseconds, then the low seconds word again, and it repeats the sequence if the two seconds values differ.

Top module: `tod_counter`

## Requirements
- R1: While reset is asserted, the seconds high word, the seconds low word and the nanoseconds field all read as zero.
- R2: On a cycle with no accepted nanoseconds write, where the sum of nanoseconds and PERIOD_NS is below 1,000,000,000, the nanoseconds field grows by PERIOD_NS at the next clock edge.
- R3: When the sum of nanoseconds and PERIOD_NS is 1,000,000,000 or more, the field becomes that sum minus 1,000,000,000, and the 64-bit seconds count grows by one on the same edge. The nanoseconds field never holds 1,000,000,000 or more.
- R4: A seconds increment while the low word is 0xFFFFFFFF sets the low word to zero and adds one to the high word. An increment from all ones in both words wraps the whole count to zero.
- R5: A read is a cycle with bus_sel=1 and bus_wr=0. It returns, in the same cycle, the current value at address 0x20 (seconds high), 0x24 (seconds low), 0x28 (nanoseconds) or 0x18 (PERIOD_NS).
- R6: A write is a cycle with bus_sel=1 and bus_wr=1. A write to 0x28 with a value below 1,000,000,000 loads that value at the next edge, and counting resumes from it one cycle later.
- R7: A write to 0x28 with a value of 1,000,000,000 or more is ignored. The field advances as if no write had occurred.
- R8: A write to 0x24 or 0x20 loads that word at the next edge, and any carry into the written word on that cycle is dropped. A low-word write during a nanoseconds wrap leaves the high word unchanged. A high-word write during a wrap that overflows the low word still clears the low word.
- R9: The period at 0x18 is read-only. Writes to 0x18, writes to unmapped addresses, and bus_wr without bus_sel change no state. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one count step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, same cycle |

## Verification
A corrupted nanoseconds value shows on the next read of 0x28 as a step different from PERIOD_NS. If the value reaches one billion or more, an extra or missing carry appears at 0x24 within one wrap interval. A wrong carry chain shows at the low or high seconds word on the very edge where the nanoseconds wrap. Because of that, the bench forces wraps next to all-ones seconds words and compares every read against a reference model that is updated on every cycle. Write-path faults, such as a lost load, a load of an out-of-range value, or a stray write to the period or an unmapped address, show on the first read after the write.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned SEC_WORDS = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam word_t NS_PER_SEC = 32'd1_000_000_000;

  // software decodes these offsets; seconds words descend from the low word
  localparam addr_t OFS_PERIOD = 8'h18;
  localparam addr_t OFS_SEC_HI = 8'h20;
  localparam addr_t OFS_SEC_LO = 8'h24;
  localparam addr_t OFS_NSEC   = 8'h28;
  localparam addr_t SEC_STRIDE = 8'h04;
endpackage

// File: rtl/tod_nsec_acc.sv
module tod_nsec_acc
  import tod_pkg::*;
#(
  parameter int unsigned PERIOD_NS = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_req,
  input  word_t ld_val,
  output word_t ns_q,
  output logic  wrap
);
  localparam word_t STEP = word_t'(PERIOD_NS);

  word_t sum;
  word_t ns_d;
  logic  wrap_raw;
  logic  ld_ok;
  logic  ns_en;

  always_comb begin
    sum      = ns_q + STEP;
    wrap_raw = (sum >= NS_PER_SEC);
    ld_ok    = ld_req && (ld_val < NS_PER_SEC);
    ns_en    = 1'b1;
    if (ld_ok)         ns_d = ld_val;
    else if (wrap_raw) ns_d = sum - NS_PER_SEC;
    else               ns_d = sum;
    wrap = wrap_raw && !ld_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ns_q <= '0;
    else if (ns_en) ns_q <= ns_d;
  end
endmodule

// File: rtl/tod_sec_word.sv
module tod_sec_word
  import tod_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inc,
  input  logic  ld_en,
  input  word_t ld_val,
  output word_t q,
  output logic  carry_out
);
  word_t d;
  logic  en;

  always_comb begin
    en        = ld_en || inc;
    d         = ld_en ? ld_val : (q + word_t'(1));
    carry_out = inc && !ld_en && (q == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/tod_regif.sv
module tod_regif
  import tod_pkg::*;
#(
  parameter int unsigned PERIOD_NS = 10
) (
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  addr_t                     bus_addr,
  input  word_t                     ns_q,
  input  logic [SEC_WORDS-1:0][WORD_W-1:0] sec_q,
  output logic                      ns_ld,
  output logic [SEC_WORDS-1:0]      sec_ld,
  output word_t                     rdata
);
  localparam word_t STEP = word_t'(PERIOD_NS);

  logic                 wr_cyc;
  logic                 rd_cyc;
  logic [SEC_WORDS-1:0] sec_hit;

  assign wr_cyc = bus_sel && bus_wr;
  assign rd_cyc = bus_sel && !bus_wr;
  assign ns_ld  = wr_cyc && (bus_addr == OFS_NSEC);

  for (genvar i = 0; i < SEC_WORDS; i++) begin : g_dec
    localparam addr_t WORD_OFS = OFS_SEC_LO - addr_t'(i) * SEC_STRIDE;
    assign sec_hit[i] = (bus_addr == WORD_OFS);
    assign sec_ld[i]  = wr_cyc && sec_hit[i];
  end

  always_comb begin
    rdata = '0;
    if (rd_cyc) begin
      if (bus_addr == OFS_NSEC)   rdata = ns_q;
      if (bus_addr == OFS_PERIOD) rdata = STEP;
      for (int i = 0; i < SEC_WORDS; i++) begin
        if (sec_hit[i]) rdata = sec_q[i];
      end
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned PERIOD_NS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  logic [1:0]                       rst_sync_q;
  logic                             rst_core_n;
  word_t                            ns_q;
  logic                             ns_wrap;
  logic                             ns_ld;
  logic [SEC_WORDS-1:0]             sec_ld;
  logic [SEC_WORDS-1:0][WORD_W-1:0] sec_q;
  logic [SEC_WORDS:0]               carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  tod_regif #(.PERIOD_NS(PERIOD_NS)) u_regif (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ns_q     (ns_q),
    .sec_q    (sec_q),
    .ns_ld    (ns_ld),
    .sec_ld   (sec_ld),
    .rdata    (bus_rdata)
  );

  tod_nsec_acc #(.PERIOD_NS(PERIOD_NS)) u_nsec (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .ld_req (ns_ld),
    .ld_val (bus_wdata),
    .ns_q   (ns_q),
    .wrap   (ns_wrap)
  );

  assign carry[0] = ns_wrap;

  for (genvar i = 0; i < SEC_WORDS; i++) begin : g_sec
    tod_sec_word u_word (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .inc       (carry[i]),
      .ld_en     (sec_ld[i]),
      .ld_val    (bus_wdata),
      .q         (sec_q[i]),
      .carry_out (carry[i+1])
    );
  end
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
  import tod_pkg::*;
#(
  parameter int unsigned PERIOD_NS = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] ns_q,
  input logic [63:0] sec_q
);
  localparam word_t STEP = word_t'(PERIOD_NS);

  logic wr_ns, wr_sec, rd_period;
  assign wr_ns     = bus_sel && bus_wr && (bus_addr == OFS_NSEC);
  assign wr_sec    = bus_sel && bus_wr && (bus_addr == OFS_SEC_LO || bus_addr == OFS_SEC_HI);
  assign rd_period = bus_sel && !bus_wr && (bus_addr == OFS_PERIOD);

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (ns_q == '0 && sec_q == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ns && (ns_q + STEP < NS_PER_SEC)) |=> (ns_q == $past(ns_q) + STEP));

  p_ns_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ns_q < NS_PER_SEC);

  p_wrap_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ns && !wr_sec && (ns_q + STEP >= NS_PER_SEC)) |=>
      (ns_q == $past(ns_q) + STEP - NS_PER_SEC && sec_q == $past(sec_q) + 64'd1));

  p_rd_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_period |-> (bus_rdata == STEP));

  p_ns_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ns && bus_wdata < NS_PER_SEC) |=> (ns_q == $past(bus_wdata)));

  p_ns_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ns && bus_wdata >= NS_PER_SEC && (ns_q + STEP < NS_PER_SEC)) |=>
      (ns_q == $past(ns_q) + STEP));
endmodule

bind tod_counter tod_counter_chk #(.PERIOD_NS(PERIOD_NS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ns_q      (ns_q),
  .sec_q     (sec_q)
);

// File: tb/tb_tod_counter.sv
`timescale 1ns/1ps
module tb_tod_counter;
  localparam int unsigned P  = 10;
  localparam logic [31:0] NS = 32'd1_000_000_000;
  localparam logic [7:0] A_PER = 8'h18, A_HI = 8'h20, A_LO = 8'h24, A_NS = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_ns = '0, m_lo = '0, m_hi = '0;

  always #5 clk = ~clk;

  tod_counter #(.PERIOD_NS(P)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      A_PER:   return P;
      A_HI:    return m_hi;
      A_LO:    return m_lo;
      A_NS:    return m_ns;
      default: return 32'd0;
    endcase
  endfunction

  // reference update for one clock edge
  task automatic model_edge(input logic s, input logic w, input logic [7:0] a, input logic [31:0] d);
    logic [32:0] sum;
    logic c0, c1;
    c0 = 1'b0;
    c1 = 1'b0;
    if (s && w && a == A_NS && d < NS) m_ns = d;
    else begin
      sum = {1'b0, m_ns} + 33'(P);
      if (sum >= {1'b0, NS}) begin m_ns = 32'(sum - {1'b0, NS}); c0 = 1'b1; end
      else m_ns = sum[31:0];
    end
    if (s && w && a == A_LO) m_lo = d;
    else begin
      c1 = c0 && (m_lo == 32'hFFFF_FFFF);
      m_lo = m_lo + 32'(c0);
    end
    if (s && w && a == A_HI) m_hi = d;
    else m_hi = m_hi + 32'(c1);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [7:0] a, input logic [31:0] d);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_edge(s, w, a, d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(tag, bus_rdata, exp_rd(a));
    step(1'b1, 1'b0, a, 32'd0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 8'h00, 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset values seen on the read path while held in reset
    bus_sel = 1'b1; bus_addr = A_NS; #1; check("R1 ns in reset", bus_rdata, 32'd0);
    bus_addr = A_LO; #1; check("R1 sec_lo in reset", bus_rdata, 32'd0);
    bus_addr = A_HI; #1; check("R1 sec_hi in reset", bus_rdata, 32'd0);
    bus_sel = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle();
    wr(A_NS, 32'd100); wr(A_LO, 32'd0); wr(A_HI, 32'd0);

    // R2: plain stepping
    rd(A_NS, "R2 step a"); rd(A_NS, "R2 step b"); rd(A_NS, "R2 step c");
    // R5: register map
    rd(A_PER, "R5 period"); rd(A_LO, "R5 sec_lo"); rd(A_HI, "R5 sec_hi");
    // R3: wrap with remainder
    wr(A_NS, NS - 32'd3);
    rd(A_NS, "R3 before wrap"); rd(A_NS, "R3 remainder"); rd(A_LO, "R3 seconds carry");
    // R4: carry into high word, then full wrap
    wr(A_HI, 32'd5); wr(A_LO, 32'hFFFF_FFFF); wr(A_NS, NS - 32'd1);
    idle(); rd(A_LO, "R4 low cleared"); rd(A_HI, "R4 high incremented");
    wr(A_HI, 32'hFFFF_FFFF); wr(A_LO, 32'hFFFF_FFFF); wr(A_NS, NS - 32'd1);
    idle(); rd(A_LO, "R4 full wrap lo"); rd(A_HI, "R4 full wrap hi");
    // R6: load and resume
    wr(A_NS, 32'd12345); rd(A_NS, "R6 loaded"); rd(A_NS, "R6 resumes");
    // R7: out-of-range nanoseconds ignored
    wr(A_NS, NS); rd(A_NS, "R7 value one billion");
    wr(A_NS, 32'hFFFF_FFFF); rd(A_NS, "R7 value all ones");
    // R8: low-word write while wrapping drops carry
    wr(A_HI, 32'd2); wr(A_LO, 32'd7); wr(A_NS, NS - 32'd5);
    wr(A_LO, 32'd40); rd(A_LO, "R8 lo written on wrap"); rd(A_HI, "R8 hi untouched");
    // R8: high-word write while low overflows
    wr(A_LO, 32'hFFFF_FFFF); wr(A_NS, NS - 32'd5);
    wr(A_HI, 32'd9); rd(A_LO, "R8 lo wraps under hi write"); rd(A_HI, "R8 hi written");
    // R9: read-only period, unmapped, unselected
    wr(A_PER, 32'd77); rd(A_PER, "R9 period read-only");
    wr(8'h30, 32'd55); wr(8'h00, 32'd66);
    step(1'b0, 1'b1, A_NS, 32'd5);
    rd(A_NS, "R9 ns after ignored writes"); rd(A_LO, "R9 lo after ignored writes");
    rd(8'h30, "R9 unmapped read"); rd(8'h00, "R9 unmapped read zero");

    // mixed random traffic against the model
    for (int it = 0; it < 4000; it++) begin
      int unsigned r;
      logic [7:0] a;
      logic [31:0] d;
      r = $urandom % 10;
      if (r < 3) idle();
      else if (r < 7) begin
        case ($urandom % 6)
          0: a = A_PER; 1: a = A_HI; 2: a = A_LO; 3: a = A_NS; 4: a = 8'h2C; default: a = A_NS;
        endcase
        rd(a, "R5 random read (R2 R3 R4 R8)");
      end else begin
        case ($urandom % 4)
          0: begin
            a = A_NS;
            case ($urandom % 3)
              0: d = NS - 32'($urandom % 40);
              1: d = $urandom % NS;
              default: d = NS + 32'($urandom % 1000);
            endcase
          end
          1: begin a = A_LO; d = ($urandom % 2) ? 32'hFFFF_FFFF - 32'($urandom % 3) : $urandom; end
          2: begin a = A_HI; d = $urandom; end
          default: begin a = 8'h18 + 8'($urandom % 24); d = $urandom; end
        endcase
        wr(a, d);
      end
    end
    rd(A_NS, "R2 final ns"); rd(A_LO, "R3 final lo"); rd(A_HI, "R4 final hi");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule